// File: doc/BRIEF.md
# Auto-Reload Interval Timer and Event Counter

This block is an up-counter with two clocking modes. In interval mode it advances on ticks from an internal time base. That time base is the system clock, the system clock divided by four, or the falling edges of a slow oscillator input, and a power-of-two prescaler then divides it further. In event mode it advances on edges seen on an external pin, and software chooses whether rising or falling edges count. When the counter is at all ones and advances, it reloads from a preload register and keeps running. It also sets a sticky overflow flag, which drives the interrupt request whenever the interrupt enable is set.

Software reaches the block through a four-address, byte-wide register port. Writes happen on a clock edge when the write strobe is high, and read data follows the address combinationally. The external pin and the slow oscillator are asynchronous to the system clock. Each passes through a synchronizer, and its edges are turned into one-cycle advance pulses inside the system clock domain.

Top module: `multi_timer`

## Requirements
- R1: After reset, every register reads zero and irq is low.
- R2: Control bit 4 is the run bit. While it is 0, the counter holds its value. Control bits 7:6 select the mode: 2'b10 is interval mode and 2'b01 is event mode. With 2'b00 or 2'b11 the counter never advances, even when the run bit is set.
- R3: In interval mode with the system clock selected (status bits 3:2 = 00), the k-th advance happens on the (k·2^N)-th rising clock edge that starts while the run bit is 1. N is control bits 2:0.
- R4: Status bits 3:2 = 01 select the system clock divided by four, so the k-th advance happens on edge k·4·2^N. Status bits 3:2 = 1x select falling edges of slow_osc, and every 2^N such edges give one advance.
- R5: In event mode, control bit 3 = 0 counts each rising edge of ext_pin once and control bit 3 = 1 counts each falling edge once. Edges of the other polarity are ignored. Control bits 2:0 have no effect in this mode.
- R6: When the counter is all ones and advances, it takes the preload value instead of wrapping to zero, and counting continues.
- R7: A write to the preload register at address 1 while the run bit is 0 also loads the counter. While the run bit is 1, such a write changes only the preload register and the counter is not disturbed.
- R8: Every overflow sets the overflow flag, which is status bit 0. The flag stays set until software writes status with bit 0 = 1. A status write with bit 0 = 0 leaves the flag as it is.
- R9: irq is high exactly when the overflow flag and the interrupt enable (status bit 1) are both 1.
- R10: The register map is address 0 for control, address 1 for preload, address 2 for the counter and address 3 for status. The counter address is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ext_pin | input | 1 | Asynchronous event input |
| slow_osc | input | 1 | Asynchronous slow time-base input |
| irq | output | 1 | Masked overflow interrupt request |

## Verification
The hardest case to reach from the ports is the exact edge on which the prescaler lets an advance through, because it depends on N, on the source divider and on when the run bit was set. The stimulus always loads the counter while it is stopped, sets the run bit and then clears it after a chosen number of edges. The run lengths sit on both sides of every multiple of 2^N, and of 4·2^N for the divided source. Reading the counter back then shows exactly how many advances happened. Overflow reload is reached by preloading values close to all ones, including all ones itself, so that a short run crosses the wrap one or more times.

// File: rtl/mt_pkg.sv
package mt_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_RSVD  = 2'b11
   } mode_e;

   typedef struct packed {
      mode_e      mode;
      logic       spare;
      logic       run;
      logic       fall_edge;
      logic [2:0] shift;
   } ctrl_t;

   localparam logic [1:0] ADDR_CTRL    = 2'd0;
   localparam logic [1:0] ADDR_PRELOAD = 2'd1;
   localparam logic [1:0] ADDR_COUNT   = 2'd2;
   localparam logic [1:0] ADDR_STATUS  = 2'd3;

   localparam logic [1:0] SRC_SYS = 2'b00;
   localparam logic [1:0] SRC_DIV = 2'b01;

endpackage

// File: rtl/mt_edge_sync.sv
module mt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic want_fall,
   output logic pulse
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("mt_edge_sync: STAGES must be at least 2");
   end

   logic [LAST:0] sh;
   logic          rise, fall;

   for (genvar i = 0; i <= LAST; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign rise  = sh[LAST-1] & ~sh[LAST];
   assign fall  = ~sh[LAST-1] & sh[LAST];
   assign pulse = want_fall ? fall : rise;

   assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_single_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler
   import mt_pkg::*;
#(
   parameter int PSC_W   = 8,
   parameter int SHIFT_W = 3,
   parameter int SYS_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [1:0]         src_sel,
   input  logic               slow_fall,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int DIV_W    = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

   if (PSC_W < MAX_SHIFT) begin : g_bad_psc
      $error("mt_prescaler: PSC_W too narrow for the shift field");
   end
   if (SYS_DIV < 2 || (SYS_DIV & (SYS_DIV - 1)) != 0) begin : g_bad_div
      $error("mt_prescaler: SYS_DIV must be a power of two of at least 2");
   end

   logic [DIV_W-1:0] div_cnt;
   logic [PSC_W-1:0] psc_cnt;
   logic [PSC_W-1:0] mask;
   logic             src_tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)         div_cnt <= '0;
      else if (src_sel == SRC_DIV) div_cnt <= div_cnt + 1'b1;
   end

   always_comb begin
      case (src_sel)
         SRC_SYS: src_tick = 1'b1;
         SRC_DIV: src_tick = (div_cnt == {DIV_W{1'b1}});
         default: src_tick = slow_fall;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) psc_cnt <= '0;
      else if (src_tick)  psc_cnt <= psc_cnt + 1'b1;
   end

   assign mask = ~({PSC_W{1'b1}} << shift);
   assign tick = run & src_tick & ((psc_cnt & mask) == mask);

   assert_div_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && src_sel == SRC_DIV && src_tick) |=> !src_tick);

endmodule

// File: rtl/mt_count_core.sv
module mt_count_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] count,
   output logic         wrap
);
   if (W < 2) begin : g_bad_w
      $error("mt_count_core: W must be at least 2");
   end

   assign wrap = adv & (count == {W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (ld)   count <= ld_val;
      else if (wrap) count <= reload_val;
      else if (adv)  count <= count + 1'b1;
   end

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld) |=> $stable(count));
   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld && count == {W{1'b1}}) |=> count == $past(reload_val));

endmodule

// File: rtl/multi_timer.sv
module multi_timer
   import mt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SYS_DIV     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       ext_pin,
   input  logic       slow_osc,
   output logic       irq
);
   localparam int DATA_W = 8;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("multi_timer: CNT_W must not exceed the data width");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] preload_q;
   logic             ie_q;
   logic [1:0]       src_q;
   logic             flag_q;

   logic             wr_ctrl, wr_pre, wr_stat;
   logic             timer_run, psc_tick, ext_pulse, slow_pulse;
   logic             adv, ld, wrap;
   logic [CNT_W-1:0] count;

   assign wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
   assign wr_pre  = reg_wr && reg_addr == ADDR_PRELOAD;
   assign wr_stat = reg_wr && reg_addr == ADDR_STATUS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         preload_q <= '0;
         ie_q      <= 1'b0;
         src_q     <= '0;
      end else begin
         if (wr_ctrl) ctrl_q    <= ctrl_t'(reg_wdata);
         if (wr_pre)  preload_q <= reg_wdata[CNT_W-1:0];
         if (wr_stat) begin
            ie_q  <= reg_wdata[1];
            src_q <= reg_wdata[3:2];
         end
      end
   end

   mt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_pin),
      .want_fall(ctrl_q.fall_edge), .pulse(ext_pulse));

   mt_edge_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
      .clk(clk), .rst_n(rst_n), .din(slow_osc),
      .want_fall(1'b1), .pulse(slow_pulse));

   assign timer_run = ctrl_q.run && ctrl_q.mode == MODE_TIMER;

   mt_prescaler #(.PSC_W(PSC_W), .SHIFT_W(3), .SYS_DIV(SYS_DIV)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(timer_run), .src_sel(src_q),
      .slow_fall(slow_pulse), .shift(ctrl_q.shift), .tick(psc_tick));

   always_comb begin
      case (ctrl_q.mode)
         MODE_TIMER: adv = psc_tick;
         MODE_EVENT: adv = ctrl_q.run & ext_pulse;
         default:    adv = 1'b0;
      endcase
   end

   assign ld = wr_pre && !ctrl_q.run;

   mt_count_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ld(ld),
      .ld_val(reg_wdata[CNT_W-1:0]), .reload_val(preload_q),
      .count(count), .wrap(wrap));

   always_ff @(posedge clk) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (wrap)                  flag_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) flag_q <= 1'b0;
   end

   assign irq = flag_q & ie_q;

   always_comb begin
      logic [DATA_W-1:0] cnt_ext;
      logic [DATA_W-1:0] pre_ext;
      cnt_ext = '0;
      pre_ext = '0;
      cnt_ext[CNT_W-1:0] = count;
      pre_ext[CNT_W-1:0] = preload_q;
      case (reg_addr)
         ADDR_CTRL:    reg_rdata = ctrl_q;
         ADDR_PRELOAD: reg_rdata = pre_ext;
         ADDR_COUNT:   reg_rdata = cnt_ext;
         default:      reg_rdata = {4'b0, src_q, ie_q, flag_q};
      endcase
   end

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_stat && reg_wdata[0])) |=> flag_q);
   assert_irq_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && ie_q && !wr_stat) |=> irq);
   assert_idle_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == MODE_OFF || ctrl_q.mode == MODE_RSVD) |-> !wrap);

endmodule

// File: tb/tb_multi_timer.sv
`timescale 1ns/1ps
module tb_multi_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ext_pin = 1'b0;
   logic       slow_osc = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   multi_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
      .slow_osc(slow_osc), .irq(irq));

   always #5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   // run for s edges with the given control value (run bit set inside)
   task automatic run_edges(input logic [7:0] c, input int s);
      wr(2'd0, c | 8'h10);
      repeat (s - 1) @(negedge clk);
      wr(2'd0, c & 8'hEF);
   endtask

   task automatic pin_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_pin = 1'b1; repeat (4) @(negedge clk);
         ext_pin = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   function automatic int model(input int p, input int start, input int incs);
      int v = start;
      for (int i = 0; i < incs; i++) v = (v == 255) ? p : v + 1;
      return v;
   endfunction

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v); chk("R1 reset register", v, 0);
      end
      chk("R1 reset irq", int'(irq), 0);

      // R3 system source, every shift, both sides of each boundary
      for (int n = 0; n < 8; n++) begin
         for (int d = 0; d < 2; d++) begin
            int s = 3 * (1 << n) - d;
            wr(2'd1, 8'h00);
            run_edges(8'h80 | n[7:0], s);
            rd(2'd2, v); chk("R3 prescaled count", v, s / (1 << n));
         end
      end

      // R4 divided system source
      wr(2'd3, 8'h04);
      for (int n = 0; n < 4; n++) begin
         for (int d = 0; d < 2; d++) begin
            int s = 2 * 4 * (1 << n) - d;
            wr(2'd1, 8'h00);
            run_edges(8'h80 | n[7:0], s);
            rd(2'd2, v); chk("R4 divided count", v, s / (4 * (1 << n)));
         end
      end

      // R4 slow oscillator source, shift 1: 7 falling edges give 3
      wr(2'd3, 8'h08);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h91);
      for (int i = 0; i < 7; i++) begin
         slow_osc = 1'b1; repeat (5) @(negedge clk);
         slow_osc = 1'b0; repeat (5) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      wr(2'd0, 8'h81);
      rd(2'd2, v); chk("R4 slow source count", v, 3);
      wr(2'd3, 8'h00);

      // R5 event mode rising edges, shift bits set to 7 (ignored)
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h57);
      pin_pulses(5);
      repeat (4) @(negedge clk);
      rd(2'd2, v); chk("R5 rising edge count", v, 5);
      // R5 falling polarity: rising edge alone must not count
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h5F);
      ext_pin = 1'b1; repeat (6) @(negedge clk);
      rd(2'd2, v); chk("R5 rising ignored when falling selected", v, 0);
      ext_pin = 1'b0; repeat (6) @(negedge clk);
      rd(2'd2, v); chk("R5 falling edge counted", v, 1);
      pin_pulses(3);
      repeat (4) @(negedge clk);
      rd(2'd2, v); chk("R5 falling edge count", v, 4);
      wr(2'd0, 8'h40);

      // R2 run clear holds; modes 00 and 11 never advance
      wr(2'd1, 8'h33);
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R2 stopped hold", v, 8'h33);
      wr(2'd0, 8'h10);
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R2 mode 00 no advance", v, 8'h33);
      wr(2'd0, 8'hD0);
      pin_pulses(2);
      rd(2'd2, v); chk("R2 mode 11 no advance", v, 8'h33);
      wr(2'd0, 8'h00);

      // R7 preload write while running leaves counter alone
      wr(2'd1, 8'h10);
      wr(2'd0, 8'h50);
      wr(2'd1, 8'hF0);
      rd(2'd2, v); chk("R7 running preload write no load", v, 8'h10);
      rd(2'd1, v); chk("R7 preload register updated", v, 8'hF0);
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h21);
      rd(2'd2, v); chk("R7 stopped preload write loads", v, 8'h21);

      // R10 counter address is read-only; control reads back
      wr(2'd2, 8'h55);
      rd(2'd2, v); chk("R10 counter write ignored", v, 8'h21);
      wr(2'd0, 8'hA3);
      rd(2'd0, v); chk("R10 control readback", v, 8'hA3);
      wr(2'd0, 8'h80);

      // R6 overflow reload, several preload values
      wr(2'd1, 8'hFC);
      run_edges(8'h80, 6);
      rd(2'd2, v); chk("R6 reload after overflow", v, model(8'hFC, 8'hFC, 6));
      rd(2'd3, v); chk("R8 flag set on overflow", v & 1, 1);
      chk("R9 irq masked", int'(irq), 0);
      wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R8 write zero keeps flag", v & 1, 1);
      chk("R9 irq enabled", int'(irq), 1);
      wr(2'd3, 8'h03);
      rd(2'd3, v); chk("R8 flag cleared", v & 1, 0);
      chk("R9 irq low after clear", int'(irq), 0);

      wr(2'd1, 8'hFF);
      run_edges(8'h80, 5);
      rd(2'd2, v); chk("R6 all-ones preload", v, 8'hFF);
      chk("R9 irq after repeated wrap", int'(irq), 1);
      wr(2'd3, 8'h01);

      wr(2'd1, 8'h80);
      run_edges(8'h80, 130);
      rd(2'd2, v); chk("R6 long run across wrap", v, model(8'h80, 8'h80, 130));
      rd(2'd3, v); chk("R8 flag with irq disabled", v & 3, 1);
      chk("R9 irq masked again", int'(irq), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule